// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of several devices onto a small set of shared interrupt lines. Every device owns four pins. Each pin is steered to one shared line by a rotation that depends on the device's slot number, so that the pins of different devices spread across the lines instead of all landing on line 0.

The block does not OR the pins together. It keeps the last level reported for every pin. For each shared line it holds a counter of how many of the pins routed to it are currently high. An update strobe comes with each pin level. An update that repeats the stored level does nothing. A real rise adds one to the counter of the mapped line, and a real fall takes one away. Changes that arrive in the same cycle are summed. A shared line is driven high for as long as its counter is nonzero. The counters themselves are brought out so that the number of active sources per line can be seen.

Top module: `shirq_agg`

## Requirements
- R1: After reset, and after any later reset, every line counter reads 0, every shared line is low, and every stored pin level is 0. A stored pin level of 0 means a following update to 1 counts as a rise.
- R2: An update whose level equals the stored level of that pin changes no counter and no line.
- R3: An update that changes a pin from 0 to 1 adds one to the counter of the pin's mapped line. The result is visible on the first clock edge that samples the update.
- R4: An update that changes a pin from 1 to 0 subtracts one from the counter of the pin's mapped line. A counter never goes below zero.
- R5: Shared line l (line_o bit l) is high exactly when the counter of line l is nonzero.
- R6: Pin p of device d maps to shared line (p + d) mod 4. The flat pin index is d*4 + p.
- R7: All rises and falls sampled on one clock edge are applied together. Each line counter moves by its number of rises minus its number of falls.
- R8: The counter of each line always equals the number of stored-high pins that map to it, and so never exceeds the number of devices.
- R9: A pin whose update strobe is low is ignored, whatever its level input shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_valid_i | input | NUM_DEV*4 | Update strobe per pin, bit d*4+p for pin p of device d |
| pin_level_i | input | NUM_DEV*4 | Reported level per pin, same bit order as the strobe |
| line_o | output | 4 | Shared interrupt lines, bit l is line l |
| line_count_o | output | 4*CNT_W | Active-source count per line, line l in bits [l*CNT_W +: CNT_W], CNT_W = clog2(4*NUM_DEV+1) |

## Verification
On every cycle, the assertions check several properties. A repeated level or an update without a strobe must leave the stored pin state alone. No counter may underflow or pass the device count. Each line output must agree with its registered counter. Each counter must equal the population of stored-high pins that the inverse rotation gathers for that line. The bench scenarios show the rest: the exact slot rotation as seen at the ports, the summing of many simultaneous rises and falls, and the clearing of all state by a reset issued in the middle of activity, followed by correct recounting.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

    localparam int unsigned PINS_PER_DEV = 4;

    // Device pin that lands on a given line for a given slot (inverse rotation).
    function automatic int unsigned pin_for_line(int unsigned line, int unsigned dev);
        return (line + PINS_PER_DEV - (dev % PINS_PER_DEV)) % PINS_PER_DEV;
    endfunction

    // Width that holds every source of every line without overflow.
    function automatic int unsigned count_width(int unsigned num_dev);
        return $clog2(PINS_PER_DEV * num_dev + 1);
    endfunction

endpackage

// File: rtl/shirq_pin_track.sv
module shirq_pin_track #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] valid_i,
    input  logic [NSRC-1:0] level_i,
    output logic [NSRC-1:0] state_o,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o
);

    typedef struct packed {
        logic [NSRC-1:0] state;
    } track_t;

    track_t trk_d, trk_q;
    logic [NSRC-1:0] change;

    always_comb begin
        trk_d  = trk_q;
        change = valid_i & (level_i ^ trk_q.state);
        rise_o = change & level_i;
        fall_o = change & ~level_i;
        trk_d.state = (trk_q.state & ~change) | (level_i & change);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign state_o = trk_q.state;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_hold_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i[i] && (level_i[i] == state_o[i])) |=> $stable(state_o[i]));
        assert_ignore_nostrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i[i] |=> $stable(state_o[i]));
        assert_take_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i[i] |=> (state_o[i] == $past(level_i[i])));
    end

endmodule

// File: rtl/shirq_swizzle.sv
module shirq_swizzle
    import shirq_pkg::*;
#(
    parameter int unsigned NUM_DEV = 4,
    parameter int unsigned CNT_W   = 5
) (
    input  logic [NUM_DEV*PINS_PER_DEV-1:0] rise_i,
    input  logic [NUM_DEV*PINS_PER_DEV-1:0] fall_i,
    output logic [PINS_PER_DEV*CNT_W-1:0]   up_o,
    output logic [PINS_PER_DEV*CNT_W-1:0]   dn_o
);

    for (genvar l = 0; l < PINS_PER_DEV; l++) begin : g_line
        logic [NUM_DEV-1:0] rise_here;
        logic [NUM_DEV-1:0] fall_here;
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            localparam int unsigned SRC = d * PINS_PER_DEV + pin_for_line(l, d);
            assign rise_here[d] = rise_i[SRC];
            assign fall_here[d] = fall_i[SRC];
        end
        assign up_o[l*CNT_W +: CNT_W] = CNT_W'($countones(rise_here));
        assign dn_o[l*CNT_W +: CNT_W] = CNT_W'($countones(fall_here));
    end

endmodule

// File: rtl/shirq_line_cnt.sv
module shirq_line_cnt #(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned MAX_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] up_i,
    input  logic [CNT_W-1:0] dn_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             line_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.cnt  = cnt_q.cnt + up_i - dn_i;
        cnt_d.line = (cnt_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q.cnt;
    assign line_o = cnt_q.line;

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, dn_i} <= ({1'b0, cnt_o} + {1'b0, up_i})));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o <= CNT_W'(MAX_SRC)));
    assert_line_iff_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == (cnt_o != '0)));
    assert_quiet_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_i == '0) && (dn_i == '0)) |=> $stable(cnt_o));

endmodule

// File: rtl/shirq_agg.sv
module shirq_agg
    import shirq_pkg::*;
#(
    parameter int unsigned NUM_DEV = 4,
    localparam int unsigned NSRC   = NUM_DEV * PINS_PER_DEV,
    localparam int unsigned NLINE  = PINS_PER_DEV,
    localparam int unsigned CNT_W  = count_width(NUM_DEV)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        pin_valid_i,
    input  logic [NSRC-1:0]        pin_level_i,
    output logic [NLINE-1:0]       line_o,
    output logic [NLINE*CNT_W-1:0] line_count_o
);

    logic [NSRC-1:0]        state;
    logic [NSRC-1:0]        rise;
    logic [NSRC-1:0]        fall;
    logic [NLINE*CNT_W-1:0] up;
    logic [NLINE*CNT_W-1:0] dn;

    shirq_pin_track #(.NSRC(NSRC)) i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (pin_valid_i),
        .level_i (pin_level_i),
        .state_o (state),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    shirq_swizzle #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) i_swz (
        .rise_i (rise),
        .fall_i (fall),
        .up_o   (up),
        .dn_o   (dn)
    );

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        shirq_line_cnt #(.CNT_W(CNT_W), .MAX_SRC(NUM_DEV)) i_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_i   (up[l*CNT_W +: CNT_W]),
            .dn_i   (dn[l*CNT_W +: CNT_W]),
            .cnt_o  (line_count_o[l*CNT_W +: CNT_W]),
            .line_o (line_o[l])
        );

        // Stored pin levels gathered per line, cross-checked against the counter.
        logic [NUM_DEV-1:0] held_here;
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            assign held_here[d] = state[d * PINS_PER_DEV + pin_for_line(l, d)];
        end

        assert_count_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (line_count_o[l*CNT_W +: CNT_W] == CNT_W'($countones(held_here))));
    end

endmodule

// File: tb/test_shirq_agg.sv
`timescale 1ns/1ps
module test_shirq_agg;

    localparam int ND = 4;
    localparam int NS = ND * 4;
    localparam int CW = $clog2(4 * ND + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS-1:0]  pin_valid_i = '0;
    logic [NS-1:0]  pin_level_i = '0;
    logic [3:0]     line_o;
    logic [4*CW-1:0] line_count_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit model [NS];

    shirq_agg #(.NUM_DEV(ND)) i_shirq_agg (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_valid_i  (pin_valid_i),
        .pin_level_i  (pin_level_i),
        .line_o       (line_o),
        .line_count_o (line_count_o)
    );

    always #2 clk = ~clk;

    // Stimulus table: upper half strobe, lower half level.
    localparam int NVEC = 12;
    localparam logic [31:0] STIM [NVEC] = '{
        32'h0001_0001, 32'h0002_0002, 32'h0010_0010, 32'h0003_0003,
        32'h0001_0000, 32'h00F0_00A0, 32'hFFFF_FFFF, 32'h0000_0000,
        32'h0000_1234, 32'h8421_0000, 32'hFFFF_0000, 32'h1111_1111
    };

    function automatic int exp_count(int l);
        int n = 0;
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < 4; p++)
                if (((p + d) % 4) == l && model[d*4+p]) n++;
        return n;
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int mask = 0;
        for (int l = 0; l < 4; l++) begin
            check_val(tag, int'(line_count_o[l*CW +: CW]), exp_count(l));
            if (exp_count(l) != 0) mask |= (1 << l);
        end
        check_val({tag, " R5 lines"}, int'(line_o), mask);
    endtask

    task automatic apply(logic [NS-1:0] v, logic [NS-1:0] lv);
        @(negedge clk);
        pin_valid_i = v;
        pin_level_i = lv;
        for (int i = 0; i < NS; i++) if (v[i]) model[i] = lv[i];
        @(posedge clk);
        #1;
        pin_valid_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NS; i++) model[i] = 1'b0;
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NS; i++) model[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 initial");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R7 R9 through the model
        for (int k = 0; k < NVEC; k++) begin
            apply(STIM[k][31:16], STIM[k][15:0]);
            if (STIM[k][31:16] == 16'h0) check_all("R9 no strobe");
            else                         check_all("R3 R4 R7 table");
        end

        // R6: slot rotation at the ports
        do_reset();
        apply(16'h0080, 16'h0080);           // device 1 pin 3 -> line 0
        check_val("R6 d1p3 line0", int'(line_count_o[0 +: CW]), 1);
        check_val("R6 d1p3 others", int'(line_o), 4'b0001);
        apply(16'h0400, 16'h0400);           // device 2 pin 2 -> line 0
        check_val("R6 d2p2 line0", int'(line_count_o[0 +: CW]), 2);
        apply(16'h4000, 16'h4000);           // device 3 pin 2 -> line 1
        check_val("R6 d3p2 line1", int'(line_o), 4'b0011);

        // R4 R5: line falls only when its last source falls
        apply(16'h0080, 16'h0000);
        check_val("R5 line0 held", int'(line_o[0]), 1);
        apply(16'h0400, 16'h0000);
        check_val("R5 line0 drops", int'(line_o[0]), 0);
        check_val("R4 line0 zero", int'(line_count_o[0 +: CW]), 0);

        // R2: a repeated high leaves the count alone
        apply(16'h4000, 16'h4000);
        check_val("R2 repeat high", int'(line_count_o[CW +: CW]), 1);

        // R9: level flips without strobe ignored
        @(negedge clk);
        pin_level_i = 16'hFFFF;
        @(posedge clk); #1;
        check_all("R9 ignored level");
        pin_level_i = '0;

        // R7 R8: all rise together, then mid-run reset clears state (R1)
        apply(16'hFFFF, 16'hFFFF);
        check_all("R7 R8 all high");
        do_reset();
        apply(16'hFFFF, 16'h0000);
        check_all("R1 R2 low after reset");
        apply(16'hFFFF, 16'hFFFF);
        check_all("R1 R3 recount after reset");
        apply(16'hFFFF, 16'h0000);
        check_all("R7 all fall");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule